// File: doc/BRIEF.md
# Serial Wiper Register with Chainable Output

This block is the digital control core of a 256-step digital potentiometer. An external controller drives a three-wire serial link into it: a serial clock, a data line and an active-low chip select. While chip select is low, each rising edge of the serial clock moves one data bit into an 8-bit input register, most significant bit first. When chip select goes high again, the contents of the input register are copied into the wiper latch. The latch output selects the resistor-ladder tap. Reset places the wiper at midscale.

The serial pins arrive asynchronously. Each passes through a two-flop synchronizer on a system clock that runs at least eight times faster than the serial clock, and edge pulses are derived from the synchronized levels. The bit displaced from the top of the input register is driven out on an open-drain serial output, so several devices can share one chip select and one clock in a chain. That output is modelled as a pull-low enable, and the external pull-up supplies the high level. Each commit produces a one-cycle load strobe.

Top module: `wiper_serial_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `wiper_o` is 0x80, `load_strobe_o` is 0, and `sdo_pull_low_o` is 0 (line released).
- R2: The first bit clocked in a window becomes bit 7 of the committed code, and the eighth bit becomes bit 0. This holds for the extreme codes 0x00 and 0xFF.
- R3: `wiper_o` keeps its value for the whole chip-select-low window, whatever number of bits has been clocked. A new code appears within 8 system clocks of chip select rising.
- R4: If more than 8 bits arrive in one window, only the last 8 received are committed.
- R5: While chip select is low, the serial line (low when `sdo_pull_low_o` is 1, high otherwise) shows the bit that the next serial-clock rise will displace from the input register. That bit is taken from the register's previous contents, MSB first. The line changes only after serial-clock falling edges.
- R6: While chip select is high, `sdo_pull_low_o` is 0.
- R7: Two chained devices driven with 16 bits in one window end with the first 8 bits in the device farther from the controller and the last 8 in the nearer one.
- R8: Every chip-select rise commits the current input register, including a window with no clock edges. Each commit gives exactly one single-cycle pulse on `load_strobe_o`.
- R9: Serial-clock edges while chip select is high leave the input register unchanged.
- R10: When the last serial-clock rise and the chip-select rise land in the same synchronized cycle, the bit of that rise is included in the committed code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous, idles low |
| sdi_i | input | 1 | Serial data in, MSB first |
| csn_i | input | 1 | Chip select, active low |
| sdo_pull_low_o | output | 1 | 1 = pull the open-drain serial output low |
| wiper_o | output | 8 | Wiper latch, ladder tap select |
| load_strobe_o | output | 1 | One-cycle pulse on every commit |

## Verification
Two functions can fall in the same system cycle: the final shift of a word and the commit. The bench provokes this by raising the serial clock and chip select in the same instant, so both pass through equal synchronizer delays and reach the edge detectors together. The result is judged at the wiper port. It must hold the full word including that last bit, not the register contents from one shift earlier. A separate case brings the serial clock out of line with chip select, to show that the commit path does not depend on the coincidence.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int unsigned DEF_WORD_W      = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned N_SER_IN        = 3;
    localparam int unsigned IX_SCLK         = 0;
    localparam int unsigned IX_SDI          = 1;
    localparam int unsigned IX_CSN          = 2;
    // idle levels per index: csn high, sdi low, sclk low
    localparam logic [N_SER_IN-1:0] SER_IDLE = 3'b100;
endpackage

// File: rtl/wsc_sync_vec.sv
module wsc_sync_vec #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        typedef struct packed {
            logic [STAGES-1:0] chain;
        } sync_st_t;

        sync_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            st_d.chain = {st_q.chain[STAGES-2:0], async_i[gi]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q.chain <= {STAGES{IDLE[gi]}};
            end else begin
                st_q <= st_d;
            end
        end

        assign level_o[gi] = st_q.chain[STAGES-1];
    end
endmodule

// File: rtl/wsc_edge_det.sv
module wsc_edge_det #(
    parameter int unsigned N     = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = level_i & ~st_q.prev;
    assign fall_o = ~level_i & st_q.prev;
endmodule

// File: rtl/wsc_shift_core.sv
module wsc_shift_core #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              out_update_i,
    input  logic              sdi_i,
    output logic [WORD_W-1:0] word_next_o,
    output logic              out_bit_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              out_bit;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.word = {st_q.word[WORD_W-2:0], sdi_i};
        end
        // present the bit that the next rise will push out
        if (out_update_i) begin
            st_d.out_bit = st_q.word[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word    <= '0;
            st_q.out_bit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_next_o = st_d.word;
    assign out_bit_o   = st_q.out_bit;
endmodule

// File: rtl/wsc_wiper_latch.sv
module wsc_wiper_latch #(
    parameter int unsigned WORD_W         = 8,
    parameter logic [WORD_W-1:0] PRESET   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] value_i,
    output logic [WORD_W-1:0] wiper_o,
    output logic              strobe_o
);
    typedef struct packed {
        logic [WORD_W-1:0] wiper;
        logic              strobe;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = commit_i;
        if (commit_i) begin
            st_d.wiper = value_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wiper  <= PRESET;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wiper_o  = st_q.wiper;
    assign strobe_o = st_q.strobe;
endmodule

// File: rtl/wiper_serial_ctrl.sv
module wiper_serial_ctrl #(
    parameter int unsigned WORD_W      = wsc_pkg::DEF_WORD_W,
    parameter int unsigned SYNC_STAGES = wsc_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              csn_i,
    output logic              sdo_pull_low_o,
    output logic [WORD_W-1:0] wiper_o,
    output logic              load_strobe_o
);
    import wsc_pkg::*;

    localparam logic [WORD_W-1:0] MIDSCALE = WORD_W'(1) << (WORD_W - 1);
    localparam int unsigned       N_EDGE   = 2;
    // edge vector: bit 0 serial clock, bit 1 chip select
    localparam logic [N_EDGE-1:0] EDGE_IDLE = {SER_IDLE[IX_CSN], SER_IDLE[IX_SCLK]};

    logic [N_SER_IN-1:0] raw_in, sync_lvl;
    logic [N_EDGE-1:0]   edge_lvl, edge_rise, edge_fall;
    logic                sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic                csn_lvl, cs_was_low, cs_low_now;
    logic                do_shift, do_out_update;
    logic [WORD_W-1:0]   word_next;
    logic                out_bit;

    always_comb begin
        raw_in           = '0;
        raw_in[IX_SCLK]  = sclk_i;
        raw_in[IX_SDI]   = sdi_i;
        raw_in[IX_CSN]   = csn_i;
    end

    wsc_sync_vec #(
        .N      (N_SER_IN),
        .STAGES (SYNC_STAGES),
        .IDLE   (SER_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .level_o (sync_lvl)
    );

    assign edge_lvl = {sync_lvl[IX_CSN], sync_lvl[IX_SCLK]};

    wsc_edge_det #(
        .N    (N_EDGE),
        .IDLE (EDGE_IDLE)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (edge_lvl),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    assign sclk_rise  = edge_rise[0];
    assign sclk_fall  = edge_fall[0];
    assign cs_rise    = edge_rise[1];
    assign cs_fall    = edge_fall[1];
    assign csn_lvl    = sync_lvl[IX_CSN];
    assign cs_low_now = ~csn_lvl;
    // chip select level one cycle back, rebuilt from level and edges
    assign cs_was_low = (cs_low_now & ~cs_fall) | cs_rise;

    // a rise in the cycle that chip select rises still counts as in-window
    assign do_shift      = sclk_rise & cs_was_low;
    assign do_out_update = cs_fall | (sclk_fall & cs_low_now);

    wsc_shift_core #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_i      (do_shift),
        .out_update_i (do_out_update),
        .sdi_i        (sync_lvl[IX_SDI]),
        .word_next_o  (word_next),
        .out_bit_o    (out_bit)
    );

    wsc_wiper_latch #(
        .WORD_W (WORD_W),
        .PRESET (MIDSCALE)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (cs_rise),
        .value_i  (word_next),
        .wiper_o  (wiper_o),
        .strobe_o (load_strobe_o)
    );

    assign sdo_pull_low_o = cs_low_now & ~out_bit;
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_i,
    input logic              sdo_pull_low_o,
    input logic [WORD_W-1:0] wiper_o,
    input logic              load_strobe_o
);
    localparam logic [WORD_W-1:0] MID = WORD_W'(1) << (WORD_W - 1);

    a_r1_midscale_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (wiper_o == MID && !load_strobe_o && !sdo_pull_low_o))
        else $error("R1 reset state wrong");

    a_r3_wiper_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> load_strobe_o)
        else $error("R3 wiper changed without commit");

    a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe_o |=> !load_strobe_o)
        else $error("R8 strobe wider than one cycle");

    a_r6_released_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_i, 1) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !sdo_pull_low_o)
        else $error("R6 output pulled low while deselected");

    a_r9_no_commit_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_i, 1) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4))
        |-> !load_strobe_o)
        else $error("R9 commit without chip select rise");
endmodule

bind wiper_serial_ctrl wsc_checker #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csn_i          (csn_i),
    .sdo_pull_low_o (sdo_pull_low_o),
    .wiper_o        (wiper_o),
    .load_strobe_o  (load_strobe_o)
);

// File: tb/sim_wiper_serial_ctrl.sv
`timescale 1ns/1ps
module sim_wiper_serial_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic csn = 1'b1;
    logic u0_pull, u1_pull, u0_strobe, u1_strobe;
    logic [7:0] u0_wiper, u1_wiper;
    logic u0_line;
    int checks = 0;
    int failures = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign u0_line = u0_pull ? 1'b0 : 1'b1;

    wiper_serial_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
        .sdo_pull_low_o(u0_pull), .wiper_o(u0_wiper), .load_strobe_o(u0_strobe));

    // second device downstream of u0 in a chain
    wiper_serial_ctrl u1 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(u0_line), .csn_i(csn),
        .sdo_pull_low_o(u1_pull), .wiper_o(u1_wiper), .load_strobe_o(u1_strobe));

    always @(negedge clk) if (u0_strobe) strobes++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic open_win();
        csn = 1'b0;
        half();
    endtask

    task automatic close_win();
        half();
        csn = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        half();
        sclk = 1'b1;
        half();
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic write_word(input logic [7:0] w);
        open_win();
        send_bits(32'(w), 8);
        close_win();
    endtask

    task automatic t_reset();
        chk("R1 wiper at reset", 32'(u0_wiper), 32'h80);
        chk("R1 line released at reset", 32'(u0_pull), 32'h0);
        chk("R1 no strobe at reset", 32'(strobes), 32'h0);
    endtask

    task automatic t_hold_and_commit();
        int s0;
        s0 = strobes;
        open_win();
        send_bits(32'h0B, 5);        // 0x5A first five bits: 01011
        chk("R3 wiper held mid window", 32'(u0_wiper), 32'h80);
        send_bits(32'h2, 3);         // remaining 010
        half();
        chk("R3 wiper held after 8 bits", 32'(u0_wiper), 32'h80);
        csn = 1'b1;
        repeat (8) @(negedge clk);
        chk("R2 R3 committed MSB first", 32'(u0_wiper), 32'h5A);
        chk("R8 one strobe per commit", 32'(strobes - s0), 32'h1);
    endtask

    task automatic t_long_word();
        open_win();
        send_bits(32'hABC, 12);
        close_win();
        chk("R4 last 8 of 12 bits", 32'(u0_wiper), 32'hBC);
    endtask

    task automatic t_extremes();
        write_word(8'h00);
        chk("R2 code 0x00", 32'(u0_wiper), 32'h00);
        write_word(8'hFF);
        chk("R2 code 0xFF", 32'(u0_wiper), 32'hFF);
    endtask

    task automatic t_sdo_stream();
        logic [7:0] got;
        write_word(8'hC3);
        open_win();
        for (int i = 7; i >= 0; i--) begin
            sdi = 1'(8'h3C >> i);
            half();
            got[i] = u0_line;        // level the next rise displaces
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        close_win();
        chk("R5 displaced bits are previous word", 32'(got), 32'hC3);
        chk("R2 new word after stream", 32'(u0_wiper), 32'h3C);
        chk("R6 released after window", 32'(u0_pull), 32'h0);
    endtask

    task automatic t_sdo_edge();
        write_word(8'h80);
        open_win();
        chk("R5 first bit shown after select", 32'(u0_line), 32'h1);
        sdi = 1'b0;
        half();
        sclk = 1'b1;
        half();
        chk("R5 line holds until falling edge", 32'(u0_line), 32'h1);
        sclk = 1'b0;
        half();
        chk("R5 line updates after falling edge", 32'(u0_line), 32'h0);
        send_bits(32'h01, 7);
        close_win();
        chk("R6 released when deselected", 32'(u0_pull), 32'h0);
        chk("R2 word after edge test", 32'(u0_wiper), 32'h01);
    endtask

    task automatic t_idle_clocks_and_empty();
        int s0;
        write_word(8'h24);
        sdi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            half();
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        chk("R9 no commit from idle clocks", 32'(u0_wiper), 32'h24);
        s0 = strobes;
        csn = 1'b0;
        repeat (12) @(negedge clk);
        csn = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 R8 empty window commits unchanged register", 32'(u0_wiper), 32'h24);
        chk("R8 empty window strobes once", 32'(strobes - s0), 32'h1);
    endtask

    task automatic t_same_cycle();
        open_win();
        send_bits(32'h4B, 7);        // 0x96 upper seven bits 1001011
        sdi = 1'b0;
        half();
        sclk = 1'b1;
        csn = 1'b1;                  // same instant as the last rise
        half();
        sclk = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 last rise with select rise included", 32'(u0_wiper), 32'h96);
    endtask

    task automatic t_chain();
        open_win();
        send_bits(32'h6D29, 16);
        close_win();
        chk("R7 far device gets first byte", 32'(u1_wiper), 32'h6D);
        chk("R7 near device gets last byte", 32'(u0_wiper), 32'h29);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_hold_and_commit();
        t_long_word();
        t_extremes();
        t_sdo_stream();
        t_sdo_edge();
        t_idle_clocks_and_empty();
        t_same_cycle();
        t_chain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule